// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a slave serial port whose clock and frame syncs come from an external master. It has separate transmit and receive paths. Each path keeps a parallel register next to its shift register, so software handles whole words while bits move on the wire. The external SCLK, the two frame-sync pins and the serial data input are brought into the system clock domain. The block then works on the rising and falling SCLK edges that it detects there.

On the transmit side, software writes a word into the holding register. At the next accepted transmit frame sync the word moves into the shift register and goes out MSB first, one bit per SCLK. A one-cycle ready pulse is raised early in the word, once the second bit is on the wire, so the next word can be written while the current one is still shifting. On the receive side, bits are assembled in a private shift register. Each complete word is copied into the receive register with a one-cycle done pulse. A word that software never reads is replaced by the next one, and a sticky flag records the loss.

Frame syncs are one SCLK wide and come one SCLK before the MSB. The master may also assert a sync during the last bit of a word, so that words follow each other with no gap. The word length is 16 bits by default.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, txd, tx_ready, tx_underflow, rx_done, rx_overflow and rx_data are all zero.
- R2: A word written with tx_wr is held until a transmit frame sync is sampled high on an SCLK falling edge while the transmitter is idle. The word then moves to the shift register and is driven on txd MSB first, one bit per SCLK rising edge, starting at the next rising edge. txd is low when no word is shifting.
- R3: tx_ready pulses for exactly one clock cycle per word, in the SCLK cycle in which the second bit of the word (bit 14 for 16-bit words) is driven.
- R4: A frame sync sampled while a word is still in progress on a path is ignored. The current word completes intact, and a word waiting in the transmit holding register stays there until the next accepted sync.
- R5: A transmit frame sync accepted while the holding register is empty sends all-zero bits and sets tx_underflow. tx_underflow stays set until the next tx_wr clears it.
- R6: After a receive frame sync, the next 16 SCLK falling edges sample rxd MSB first. After the last of them, rx_data holds the word and rx_done pulses for one clock cycle. rx_data does not change at any other time.
- R7: A frame sync sampled on the falling edge of a word's last bit starts the next word at once on both paths, with no idle SCLK cycle between the words.
- R8: If a word completes while the previous one has not been read (no rx_rd since its rx_done), rx_data is overwritten and rx_overflow is set. rx_overflow stays set until rx_rd, and rx_rd clears it. A word that was read is never counted as lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial bit clock from the master |
| tfs | input | 1 | Transmit frame sync from the master |
| rfs | input | 1 | Receive frame sync from the master |
| rxd | input | 1 | Serial receive data |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | WORD_W | Word to transmit |
| rx_rd | input | 1 | Read strobe acknowledging the receive register |
| txd | output | 1 | Serial transmit data |
| tx_ready | output | 1 | One-cycle pulse: holding register may be reloaded |
| tx_underflow | output | 1 | Sticky: a frame started with no word loaded |
| rx_data | output | WORD_W | Receive register |
| rx_done | output | 1 | One-cycle pulse: new word in rx_data |
| rx_overflow | output | 1 | Sticky: an unread word was overwritten |

## Verification
A wrong bit counter on the transmit side shows up on txd within the same word. The word comes out rotated or truncated, and the ready pulse moves away from the second bit cycle, so the frame comparison catches it before the next sync. A holding-register flag stuck in the wrong state shows at the next frame as a zero word or a repeated word, and the underflow flag takes the wrong value. A receive counter or an unread flag in the wrong state gives a misaligned rx_data, a missing or extra done pulse, or an overflow flag that disagrees with the read history. The scoreboard checks each of these as soon as the word completes.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   // Pins from the external master that are brought into the clk domain.
   typedef struct packed {
      logic sclk;
      logic tfs;
      logic rfs;
      logic rxd;
   } ssp_pins_t;

   localparam int PINS_W = $bits(ssp_pins_t);
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("ssp_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/ssp_tx_path.sv
module ssp_tx_path #(
   parameter int WORD_W    = 16,
   parameter int READY_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              fs,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   output logic              txd,
   output logic              ready,
   output logic              underflow
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] READY_IDX = CNT_W'(READY_BIT);

   logic [WORD_W-1:0] hold, shreg;
   logic              hold_full, active;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         shreg     <= '0;
         hold_full <= 1'b0;
         active    <= 1'b0;
         cnt       <= '0;
         txd       <= 1'b0;
         ready     <= 1'b0;
         underflow <= 1'b0;
      end else begin
         ready <= 1'b0;
         // accept a frame sync only between words
         if (sclk_fall && fs && !active) begin
            shreg     <= hold_full ? hold : '0;
            active    <= 1'b1;
            cnt       <= '0;
            hold_full <= 1'b0;
            if (!hold_full) underflow <= 1'b1;
         end
         if (sclk_rise) begin
            if (active) begin
               txd   <= shreg[WORD_W-1];
               shreg <= {shreg[WORD_W-2:0], 1'b0};
               cnt   <= cnt + 1'b1;
               if (cnt == READY_IDX) ready  <= 1'b1;
               if (cnt == LAST_IDX)  active <= 1'b0;
            end else begin
               txd <= 1'b0;
            end
         end
         // a write in the same cycle as a transfer refills the register
         if (wr) begin
            hold      <= wdata;
            hold_full <= 1'b1;
            underflow <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ssp_rx_path.sv
module ssp_rx_path #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_fall,
   input  logic              fs,
   input  logic              sdi,
   input  logic              rd,
   output logic [WORD_W-1:0] data,
   output logic              done,
   output logic              overflow
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   logic [WORD_W-2:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              active, unread, last_bit;

   assign last_bit = active && (cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         cnt      <= '0;
         active   <= 1'b0;
         unread   <= 1'b0;
         data     <= '0;
         done     <= 1'b0;
         overflow <= 1'b0;
      end else begin
         done <= 1'b0;
         if (rd) begin
            unread   <= 1'b0;
            overflow <= 1'b0;
         end
         if (sclk_fall) begin
            if (active) begin
               shreg <= {shreg[WORD_W-3:0], sdi};
               cnt   <= cnt + 1'b1;
               if (last_bit) begin
                  data   <= {shreg, sdi};
                  done   <= 1'b1;
                  active <= 1'b0;
                  unread <= 1'b1;
                  if (unread && !rd) overflow <= 1'b1;
               end
            end
            // a sync on the last bit chains the next word
            if (fs && (!active || last_bit)) begin
               active <= 1'b1;
               cnt    <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int READY_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              tfs,
   input  logic              rfs,
   input  logic              rxd,
   input  logic              tx_wr,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              rx_rd,
   output logic              txd,
   output logic              tx_ready,
   output logic              tx_underflow,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_done,
   output logic              rx_overflow
);
   import ssp_pkg::*;

   if (WORD_W < 4) begin : g_bad_width
      $error("sync_serial_port: WORD_W must be at least 4");
   end
   if (READY_BIT < 0 || READY_BIT >= WORD_W) begin : g_bad_ready
      $error("sync_serial_port: READY_BIT must index a bit of the word");
   end

   ssp_pins_t pins_raw, pins_s;
   logic      sclk_d, sclk_rise, sclk_fall;

   assign pins_raw = '{sclk: sclk, tfs: tfs, rfs: rfs, rxd: rxd};

   ssp_sync #(.WIDTH(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= pins_s.sclk;
   end
   assign sclk_rise = pins_s.sclk & ~sclk_d;
   assign sclk_fall = ~pins_s.sclk & sclk_d;

   ssp_tx_path #(.WORD_W(WORD_W), .READY_BIT(READY_BIT)) u_tx (
      .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .fs(pins_s.tfs), .wr(tx_wr), .wdata(tx_data),
      .txd(txd), .ready(tx_ready), .underflow(tx_underflow)
   );

   ssp_rx_path #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall),
      .fs(pins_s.rfs), .sdi(pins_s.rxd), .rd(rx_rd),
      .data(rx_data), .done(rx_done), .overflow(rx_overflow)
   );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_wr,
   input logic              rx_rd,
   input logic              tx_ready,
   input logic              tx_underflow,
   input logic [WORD_W-1:0] rx_data,
   input logic              rx_done,
   input logic              rx_overflow
);
   // R3: ready is a single-cycle pulse
   a_r3_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |=> !tx_ready);

   // R6: done is a single-cycle pulse
   a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R6: receive register moves only together with done
   a_r6_data_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> rx_done);

   // R5: underflow is sticky until a write
   a_r5_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_underflow && !tx_wr) |=> tx_underflow);

   // R5: a write clears underflow
   a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !tx_underflow);

   // R8: overflow is sticky until a read
   a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overflow && !rx_rd) |=> rx_overflow);

   // R8: a read clears overflow
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd |=> !rx_overflow);

   // R8: overflow can only rise with a completed word
   a_r8_rise_with_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overflow) |-> rx_done);
endmodule

bind sync_serial_port ssp_checker #(.WORD_W(WORD_W)) u_ssp_checker (
   .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .rx_rd(rx_rd),
   .tx_ready(tx_ready), .tx_underflow(tx_underflow), .rx_data(rx_data),
   .rx_done(rx_done), .rx_overflow(rx_overflow)
);

// File: tb/sync_serial_port_tb_top.sv
module sync_serial_port_tb_top;
   localparam int W    = 16;
   localparam int HALF = 8;   // clk cycles per SCLK phase

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, tfs = 1'b0, rfs = 1'b0, rxd = 1'b0;
   logic tx_wr = 1'b0, rx_rd = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic txd, tx_ready, tx_underflow, rx_done, rx_overflow;
   logic [W-1:0] rx_data;

   int n_chk = 0, n_fail = 0;
   bit ready_seen = 1'b0;
   logic [W-1:0] tx_q[$];
   logic [W-1:0] rx_q[$];

   always #2.5 clk = ~clk;

   sync_serial_port #(.WORD_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .tfs(tfs), .rfs(rfs), .rxd(rxd),
      .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .txd(txd),
      .tx_ready(tx_ready), .tx_underflow(tx_underflow), .rx_data(rx_data),
      .rx_done(rx_done), .rx_overflow(rx_overflow)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: tx ready latch and receive scoreboard
   always @(negedge clk) begin
      if (tx_ready) ready_seen = 1'b1;
      if (rst_n && rx_done) begin
         if (rx_q.size() == 0) chk("R6 unexpected rx_done", 32'h1, 32'h0);
         else chk("R6 rx word", 32'(rx_data), 32'(rx_q.pop_front()));
      end
   end

   // one SCLK cycle as the master: drive on rise, sample txd before fall
   task automatic sclk_cycle(input logic fs_t, input logic fs_r, input logic d,
                             output logic q, output bit rdy);
      sclk = 1'b1; tfs = fs_t; rfs = fs_r; rxd = d; ready_seen = 1'b0;
      repeat (HALF) @(negedge clk);
      q = txd;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      rdy = ready_seen;
   endtask

   task automatic fs_cycle();
      logic q; bit r;
      sclk_cycle(1'b1, 1'b1, 1'b0, q, r);
   endtask

   task automatic idle_cycles(input int n);
      logic q; bit r;
      for (int i = 0; i < n; i++) sclk_cycle(1'b0, 1'b0, 1'b0, q, r);
   endtask

   task automatic load_tx(input logic [W-1:0] w);
      tx_q.push_back(w);
      tx_data = w; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic read_rx();
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   // one word on both paths; checks txd word and the ready position
   task automatic frame(input string req, input logic [W-1:0] rw,
                        input bit fs_last, input int mid_fs);
      logic [W-1:0] tw; logic q; bit r;
      int rdy_idx = -1, rdy_cnt = 0;
      logic [W-1:0] exp_tx;
      rx_q.push_back(rw);
      for (int i = 0; i < W; i++) begin
         logic fs;
         fs = (fs_last && i == W-1) || (i == mid_fs);
         sclk_cycle(fs, fs, rw[W-1-i], q, r);
         tw[W-1-i] = q;
         if (r) begin rdy_cnt++; rdy_idx = i; end
      end
      exp_tx = (tx_q.size() != 0) ? tx_q.pop_front() : '0;
      chk({req, " txd word"}, 32'(tw), 32'(exp_tx));
      chk("R3 ready count", rdy_cnt, 1);
      chk("R3 ready in second-bit cycle", rdy_idx, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 txd", 32'(txd), 0);
      chk("R1 tx_ready", 32'(tx_ready), 0);
      chk("R1 tx_underflow", 32'(tx_underflow), 0);
      chk("R1 rx_done", 32'(rx_done), 0);
      chk("R1 rx_overflow", 32'(rx_overflow), 0);
      chk("R1 rx_data", 32'(rx_data), 0);
      idle_cycles(2);

      // R2 / R6 basic word
      load_tx(16'hA5C3);
      fs_cycle();
      frame("R2", 16'h3C96, 1'b0, -1);
      read_rx();
      idle_cycles(1);
      chk("R2 txd idle low", 32'(txd), 0);
      chk("R8 no overflow after read", 32'(rx_overflow), 0);

      // R5 underflow
      fs_cycle();
      frame("R5", 16'h0001, 1'b0, -1);
      read_rx();
      chk("R5 underflow set", 32'(tx_underflow), 1);
      idle_cycles(2);
      chk("R5 underflow sticky", 32'(tx_underflow), 1);
      load_tx(16'h8001);
      chk("R5 write clears underflow", 32'(tx_underflow), 0);

      // R4 mid-word sync ignored, waiting word kept
      fs_cycle();
      load_tx(16'h7E11);
      frame("R4", 16'hFFFF, 1'b0, 5);
      read_rx();
      idle_cycles(1);
      chk("R6 rx_data stable when idle", 32'(rx_data), 32'hFFFF);
      fs_cycle();
      frame("R4 held word", 16'h0000, 1'b0, -1);
      read_rx();
      chk("R5 no underflow with word loaded", 32'(tx_underflow), 0);

      // R7 back-to-back words
      load_tx(16'h1234);
      fs_cycle();
      load_tx(16'hFEDC);
      frame("R7 first", 16'hBEEF, 1'b1, -1);
      read_rx();
      frame("R7 second", 16'h5A5A, 1'b0, -1);
      chk("R7 second word in rx_data", 32'(rx_data), 32'h5A5A);
      chk("R8 read between words avoids overflow", 32'(rx_overflow), 0);
      read_rx();
      idle_cycles(1);

      // R8 overwrite of unread word
      fs_cycle();
      frame("R8 a", 16'h0F0F, 1'b0, -1);
      chk("R8 no overflow yet", 32'(rx_overflow), 0);
      fs_cycle();
      frame("R8 b", 16'hC001, 1'b0, -1);
      chk("R8 overflow set", 32'(rx_overflow), 1);
      chk("R8 overwritten data", 32'(rx_data), 32'hC001);
      idle_cycles(1);
      chk("R8 overflow sticky", 32'(rx_overflow), 1);
      read_rx();
      chk("R8 read clears overflow", 32'(rx_overflow), 0);
      fs_cycle();
      frame("R8 c", 16'h2468, 1'b0, -1);
      chk("R8 read word not counted lost", 32'(rx_overflow), 0);
      idle_cycles(1);

      chk("R6 all words delivered", rx_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule